// File: doc/BRIEF.md
# Secure Security-Configuration Register Bank

This block is a 32-bit memory-mapped register file that sits in a 4 KB secure address window. It holds the system-wide security settings: a one-bit secure-response selector, a two-bit non-secure-callable setting, a bridge interrupt enable field, and the port masks for the peripheral protection controllers. Each controller has a non-secure mask and a secure-privileged mask. There are two internal APB controllers, a set of expansion APB controllers and a set of expansion AHB controllers. Every stored mask and setting also drives an output level, so the controllers and the core see the configuration directly.

A bus master reads and writes through a simple single-cycle slave port. A write takes effect on the clock edge at which it is presented. Read data is combinational from the address. The block never signals an error. A write narrower than a word is dropped. A narrower read returns the addressed byte lane or halfword lane. The block also holds fixed identification bytes and a few registers that are read-only or write-only. These are handled so that software sees stable values.

Top module: `sec_cfg_bank`

## Requirements
- R1: After reset, and after any later reset, the secure-response and non-secure-callable outputs, the bridge enable field and every port mask read and drive zero.
- R2: A word write to offset 0x10 stores bit 0 only and drives `sec_resp_o`. A word write to 0x14 stores bits [1:0] only and drives `nsc_cfg_o`. Both values read back at their offsets.
- R3: A write takes effect only when `bus_size` is 2 (word) and `bus_addr[1:0]` is 0. A byte write (size 0) or halfword write (size 1), and an unaligned word write, change no state.
- R4: A read with `bus_size` 0 returns bits [7:0] of the word shifted right by 8*`bus_addr[1:0]`. Size 1 returns bits [15:0] of that shifted word. Size 2 returns the whole word. Unused upper bits are zero.
- R5: Port masks live in 16-byte groups, and the controller index is `bus_addr[3:2]`. The non-secure masks are internal APB at 0x70/0x74, expansion APB at 0x80–0x8C and expansion AHB at 0x60–0x6C. The secure-privileged masks are internal APB at 0xB0/0xB4, expansion APB at 0xC0–0xCC and expansion AHB at 0xA0–0xAC. Controller i drives bits [i*MASK_W +: MASK_W] of its output bus.
- R6: A stored mask keeps only the bits below that controller's port count. The upper bits read as zero and drive zero.
- R7: The internal AHB mask offsets 0x50 and 0x90, and the bridge status at 0x40, always read zero and ignore writes.
- R8: The bridge enable at 0x48 keeps bits [31:16] of a write. Bits [15:0] read zero.
- R9: The clear offsets 0x24, 0x34 and 0x44 read as zero. Writes to the identification offsets have no effect.
- R10: The twelve identification words at 0xFD0–0xFFC return, in address order, 0x04, 0x00, 0x00, 0x00, 0x52, 0xB8, V, 0x00, 0x0D, 0xF0, 0x05, 0xB1. V is 0x0B when `ALT_ID` is 0 and 0x2B otherwise.
- R11: An unmapped offset, including a controller index at or beyond the number of controllers, reads zero and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| sec_resp_o | output | 1 | Secure-response setting |
| nsc_cfg_o | output | 2 | Non-secure-callable setting |
| int_ns_o | output | 2*MASK_W | Internal APB non-secure masks |
| int_sp_o | output | 2*MASK_W | Internal APB secure-privileged masks |
| xapb_ns_o | output | N_EXP*MASK_W | Expansion APB non-secure masks |
| xapb_sp_o | output | N_EXP*MASK_W | Expansion APB secure-privileged masks |
| xahb_ns_o | output | N_EXP*MASK_W | Expansion AHB non-secure masks |
| xahb_sp_o | output | N_EXP*MASK_W | Expansion AHB secure-privileged masks |

## Verification
The bound checker watches several things on every cycle. It confirms that sub-word writes leave every output unchanged, that configuration writes reach their outputs with the right truncation, and that unused mask bits stay zero. It also checks the fixed read values of the zero, clear, bridge and identification offsets. Other behaviour only the directed scenarios can show. This includes the placement of each controller's mask on its output slice, the byte-lane extraction of narrow reads, unmapped and out-of-range indices, and the return to zero on a second reset.

// File: rtl/sec_cfg_bank.sv
module sec_cfg_bank #(
  parameter int MASK_W     = 16,
  parameter int N_EXP      = 4,
  parameter int INT0_PORTS = 12,
  parameter int INT1_PORTS = 1,
  parameter int XAPB_PORTS = 16,
  parameter int XAHB_PORTS = 10,
  parameter bit ALT_ID     = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [11:0]             bus_addr,
  input  logic [1:0]              bus_size,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    sec_resp_o,
  output logic [1:0]              nsc_cfg_o,
  output logic [2*MASK_W-1:0]     int_ns_o,
  output logic [2*MASK_W-1:0]     int_sp_o,
  output logic [N_EXP*MASK_W-1:0] xapb_ns_o,
  output logic [N_EXP*MASK_W-1:0] xapb_sp_o,
  output logic [N_EXP*MASK_W-1:0] xahb_ns_o,
  output logic [N_EXP*MASK_W-1:0] xahb_sp_o
);
  localparam logic [MASK_W-1:0] INT0_M = MASK_W'((64'd1 << INT0_PORTS) - 64'd1);
  localparam logic [MASK_W-1:0] INT1_M = MASK_W'((64'd1 << INT1_PORTS) - 64'd1);
  localparam logic [MASK_W-1:0] XAPB_M = MASK_W'((64'd1 << XAPB_PORTS) - 64'd1);
  localparam logic [MASK_W-1:0] XAHB_M = MASK_W'((64'd1 << XAHB_PORTS) - 64'd1);
  localparam logic [7:0] ID_VER = ALT_ID ? 8'h2B : 8'h0B;

  logic [7:0] grp;
  logic [1:0] idx;
  logic       wr_word;

  assign grp     = bus_addr[11:4];
  assign idx     = bus_addr[3:2];
  assign wr_word = bus_sel && bus_wr && (bus_size == 2'd2) && (bus_addr[1:0] == 2'd0);

  logic              resp_q;
  logic [1:0]        nsc_q;
  logic [15:0]       brg_q;
  logic [MASK_W-1:0] int_ns [2];
  logic [MASK_W-1:0] int_sp [2];
  logic [MASK_W-1:0] xapb_ns [N_EXP];
  logic [MASK_W-1:0] xapb_sp [N_EXP];
  logic [MASK_W-1:0] xahb_ns [N_EXP];
  logic [MASK_W-1:0] xahb_sp [N_EXP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= 1'b0;
      nsc_q  <= 2'd0;
      brg_q  <= 16'd0;
    end else if (wr_word && grp == 8'h01 && idx == 2'd0) begin
      resp_q <= bus_wdata[0];
    end else if (wr_word && grp == 8'h01 && idx == 2'd1) begin
      nsc_q <= bus_wdata[1:0];
    end else if (wr_word && grp == 8'h04 && idx == 2'd2) begin
      brg_q <= bus_wdata[31:16];
    end
  end

  assign sec_resp_o = resp_q;
  assign nsc_cfg_o  = nsc_q;

  for (genvar g = 0; g < 2; g++) begin : g_int
    localparam logic [MASK_W-1:0] IM = (g == 0) ? INT0_M : INT1_M;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        int_ns[g] <= '0;
        int_sp[g] <= '0;
      end else if (wr_word && idx == 2'(g)) begin
        if (grp == 8'h07) int_ns[g] <= bus_wdata[MASK_W-1:0] & IM;
        if (grp == 8'h0B) int_sp[g] <= bus_wdata[MASK_W-1:0] & IM;
      end
    end
    assign int_ns_o[g*MASK_W +: MASK_W] = int_ns[g];
    assign int_sp_o[g*MASK_W +: MASK_W] = int_sp[g];
  end

  for (genvar g = 0; g < N_EXP; g++) begin : g_exp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xapb_ns[g] <= '0;
        xapb_sp[g] <= '0;
        xahb_ns[g] <= '0;
        xahb_sp[g] <= '0;
      end else if (wr_word && idx == 2'(g)) begin
        if (grp == 8'h08) xapb_ns[g] <= bus_wdata[MASK_W-1:0] & XAPB_M;
        if (grp == 8'h0C) xapb_sp[g] <= bus_wdata[MASK_W-1:0] & XAPB_M;
        if (grp == 8'h06) xahb_ns[g] <= bus_wdata[MASK_W-1:0] & XAHB_M;
        if (grp == 8'h0A) xahb_sp[g] <= bus_wdata[MASK_W-1:0] & XAHB_M;
      end
    end
    assign xapb_ns_o[g*MASK_W +: MASK_W] = xapb_ns[g];
    assign xapb_sp_o[g*MASK_W +: MASK_W] = xapb_sp[g];
    assign xahb_ns_o[g*MASK_W +: MASK_W] = xahb_ns[g];
    assign xahb_sp_o[g*MASK_W +: MASK_W] = xahb_sp[g];
  end

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:    return 8'h04;
      4'd4:    return 8'h52;
      4'd5:    return 8'hB8;
      4'd6:    return ID_VER;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  logic [31:0] word;
  logic [31:0] shifted;
  logic [9:0]  id_off;
  logic        exp_ok;

  assign id_off = bus_addr[11:2] - 10'h3F4;
  assign exp_ok = 32'(idx) < N_EXP;

  always_comb begin
    word = '0;
    case (grp)
      8'h01: begin
        if (idx == 2'd0) word[0]   = resp_q;
        if (idx == 2'd1) word[1:0] = nsc_q;
      end
      8'h04:   if (idx == 2'd2) word[31:16] = brg_q;
      8'h07:   if (!idx[1]) word[MASK_W-1:0] = int_ns[idx[0]];
      8'h0B:   if (!idx[1]) word[MASK_W-1:0] = int_sp[idx[0]];
      8'h08:   if (exp_ok) word[MASK_W-1:0] = xapb_ns[idx];
      8'h0C:   if (exp_ok) word[MASK_W-1:0] = xapb_sp[idx];
      8'h06:   if (exp_ok) word[MASK_W-1:0] = xahb_ns[idx];
      8'h0A:   if (exp_ok) word[MASK_W-1:0] = xahb_sp[idx];
      8'hFD, 8'hFE, 8'hFF: begin
        if (bus_addr[11:2] >= 10'h3F4) word[7:0] = id_byte(id_off[3:0]);
      end
      default: word = '0;
    endcase
  end

  assign shifted = word >> {bus_addr[1:0], 3'b000};

  always_comb begin
    case (bus_size)
      2'd0:    bus_rdata = {24'd0, shifted[7:0]};
      2'd1:    bus_rdata = {16'd0, shifted[15:0]};
      default: bus_rdata = word;
    endcase
  end
endmodule

// File: rtl/sec_cfg_bank_chk.sv
module sec_cfg_bank_chk #(
  parameter int MASK_W     = 16,
  parameter int N_EXP      = 4,
  parameter int INT1_PORTS = 1,
  parameter bit ALT_ID     = 1'b0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_sel,
  input logic                    bus_wr,
  input logic [11:0]             bus_addr,
  input logic [1:0]              bus_size,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic                    sec_resp_o,
  input logic [1:0]              nsc_cfg_o,
  input logic [2*MASK_W-1:0]     int_ns_o,
  input logic [2*MASK_W-1:0]     int_sp_o,
  input logic [N_EXP*MASK_W-1:0] xapb_ns_o,
  input logic [N_EXP*MASK_W-1:0] xapb_sp_o,
  input logic [N_EXP*MASK_W-1:0] xahb_ns_o,
  input logic [N_EXP*MASK_W-1:0] xahb_sp_o
);
  logic rd_word;
  assign rd_word = bus_sel && !bus_wr && bus_size == 2'd2;

  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |->
    (!sec_resp_o && nsc_cfg_o == 2'd0 && int_ns_o == '0 && xapb_sp_o == '0)); // R1
  AST_RESP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_size == 2'd2 && bus_addr == 12'h010) |=> sec_resp_o == $past(bus_wdata[0])); // R2
  AST_NSC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_size == 2'd2 && bus_addr == 12'h014) |=> nsc_cfg_o == $past(bus_wdata[1:0])); // R2
  AST_NARROW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_size != 2'd2) |=>
    ($stable(sec_resp_o) && $stable(nsc_cfg_o) && $stable(int_ns_o) && $stable(int_sp_o) &&
     $stable(xapb_ns_o) && $stable(xapb_sp_o) && $stable(xahb_ns_o) && $stable(xahb_sp_o))); // R3
  AST_BYTE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_size == 2'd0) |-> bus_rdata[31:8] == 24'd0); // R4
  AST_INT1_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ns_o[2*MASK_W-1:MASK_W] >> INT1_PORTS) == '0); // R6
  AST_AHB_INT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && (bus_addr == 12'h050 || bus_addr == 12'h090 || bus_addr == 12'h040)) |-> bus_rdata == 32'd0); // R7
  AST_BRG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && bus_addr == 12'h048) |-> bus_rdata[15:0] == 16'd0); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && (bus_addr == 12'h024 || bus_addr == 12'h034 || bus_addr == 12'h044)) |-> bus_rdata == 32'd0); // R9
  AST_ID_VER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && bus_addr == 12'hFE8) |-> bus_rdata == (ALT_ID ? 32'h2B : 32'h0B)); // R10
endmodule

bind sec_cfg_bank sec_cfg_bank_chk #(
  .MASK_W(MASK_W), .N_EXP(N_EXP), .INT1_PORTS(INT1_PORTS), .ALT_ID(ALT_ID)
) chk (.*);

// File: tb/sec_cfg_bank_test.sv
module sec_cfg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 16;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sec_resp_o;
  logic [1:0] nsc_cfg_o;
  logic [2*MW-1:0] int_ns_o, int_sp_o;
  logic [NE*MW-1:0] xapb_ns_o, xapb_sp_o, xahb_ns_o, xahb_sp_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_cfg_bank uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset(input string tag);
    logic [31:0] d;
    check({tag, " resp out"}, 64'(sec_resp_o), 0);
    check({tag, " nsc out"}, 64'(nsc_cfg_o), 0);
    check({tag, " masks out"}, 64'(|{int_ns_o, int_sp_o, xapb_ns_o, xapb_sp_o, xahb_ns_o, xahb_sp_o}), 0);
    bus_read(12'h010, 2'd2, d); check({tag, " read 0x10"}, 64'(d), 0);
    bus_read(12'h048, 2'd2, d); check({tag, " read 0x48"}, 64'(d), 0);
    bus_read(12'h0C4, 2'd2, d); check({tag, " read 0xC4"}, 64'(d), 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    bus_write(12'h010, 32'hFFFF_FFFF, 2'd2);
    check("R2 resp out", 64'(sec_resp_o), 1);
    bus_read(12'h010, 2'd2, d); check("R2 resp read", 64'(d), 1);
    bus_write(12'h014, 32'hFFFF_FFFE, 2'd2);
    check("R2 nsc out", 64'(nsc_cfg_o), 2);
    bus_read(12'h014, 2'd2, d); check("R2 nsc read", 64'(d), 2);
  endtask

  task automatic t_narrow_write();
    logic [31:0] d;
    bus_write(12'h010, 32'h0, 2'd0);
    check("R3 byte write", 64'(sec_resp_o), 1);
    bus_write(12'h014, 32'h1, 2'd1);
    check("R3 half write", 64'(nsc_cfg_o), 2);
    bus_write(12'h011, 32'h0, 2'd2);
    check("R3 unaligned word", 64'(sec_resp_o), 1);
    bus_write(12'h084, 32'hFFFF, 2'd1);
    bus_read(12'h084, 2'd2, d); check("R3 half to mask", 64'(d), 0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    bus_write(12'h048, 32'hA5C3_1234, 2'd2);
    bus_read(12'h048, 2'd2, d); check("R8 brg word", 64'(d), 64'hA5C3_0000);
    bus_read(12'h04B, 2'd0, d); check("R4 byte lane3", 64'(d), 64'hA5);
    bus_read(12'h04A, 2'd0, d); check("R4 byte lane2", 64'(d), 64'hC3);
    bus_read(12'h048, 2'd0, d); check("R4 byte lane0", 64'(d), 0);
    bus_read(12'h04A, 2'd1, d); check("R4 half upper", 64'(d), 64'hA5C3);
    bus_read(12'h04B, 2'd1, d); check("R4 half lane3", 64'(d), 64'hA5);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    bus_write(12'h084, 32'h1234_5678, 2'd2);
    bus_read(12'h084, 2'd2, d); check("R5 xapb ns1 read", 64'(d), 64'h5678);
    check("R5 xapb ns slice1", 64'(xapb_ns_o), 64'h0000_0000_5678_0000);
    bus_write(12'h0CC, 32'hFFFF, 2'd2);
    check("R5 xapb sp slice3", 64'(xapb_sp_o), 64'hFFFF_0000_0000_0000);
    bus_write(12'h06C, 32'hFFFF, 2'd2);
    check("R6 xahb ns slice3", 64'(xahb_ns_o), 64'h03FF_0000_0000_0000);
    bus_write(12'h0A4, 32'hFFFF_FFFF, 2'd2);
    bus_read(12'h0A4, 2'd2, d); check("R6 xahb sp1 read", 64'(d), 64'h03FF);
    check("R5 xahb sp slice1", 64'(xahb_sp_o), 64'h0000_0000_03FF_0000);
    bus_write(12'h074, 32'hFFFF, 2'd2);
    check("R6 int ns1", 64'(int_ns_o), 64'h0001_0000);
    bus_write(12'h0B0, 32'hFFFF, 2'd2);
    check("R6 int sp0", 64'(int_sp_o), 64'h0000_0FFF);
    bus_read(12'h0B0, 2'd2, d); check("R5 int sp0 read", 64'(d), 64'h0FFF);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    bus_write(12'h050, 32'hFFFF_FFFF, 2'd2);
    bus_write(12'h090, 32'hFFFF_FFFF, 2'd2);
    bus_write(12'h040, 32'hFFFF_FFFF, 2'd2);
    bus_read(12'h050, 2'd2, d); check("R7 0x50", 64'(d), 0);
    bus_read(12'h090, 2'd2, d); check("R7 0x90", 64'(d), 0);
    bus_read(12'h040, 2'd2, d); check("R7 0x40", 64'(d), 0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bus_write(12'h024, 32'hFFFF_FFFF, 2'd2);
    bus_write(12'h034, 32'hFFFF_FFFF, 2'd2);
    bus_write(12'h044, 32'hFFFF_FFFF, 2'd2);
    bus_read(12'h024, 2'd2, d); check("R9 0x24", 64'(d), 0);
    bus_read(12'h034, 2'd2, d); check("R9 0x34", 64'(d), 0);
    bus_read(12'h044, 2'd2, d); check("R9 0x44", 64'(d), 0);
    bus_read(12'h048, 2'd2, d); check("R9 brg kept", 64'(d), 64'hA5C3_0000);
    bus_write(12'hFE8, 32'hFF, 2'd2);
    bus_read(12'hFE8, 2'd2, d); check("R9 id write ignored", 64'(d), 64'h0B);
  endtask

  function automatic logic [7:0] id_exp(input int k);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h52, 8'hB8, 8'h0B, 8'h00,
                           8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  task automatic t_id();
    logic [31:0] d;
    for (int k = 0; k < 12; k++) begin
      bus_read(12'hFD0 + 12'(4*k), 2'd2, d);
      check($sformatf("R10 id word %0d", k), 64'(d), 64'(id_exp(k)));
    end
    bus_read(12'hFCC, 2'd2, d); check("R11 below id", 64'(d), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [63:0] before_ns, before_sp;
    before_ns = 64'(int_ns_o);
    before_sp = 64'(int_sp_o);
    bus_write(12'h100, 32'hFFFF_FFFF, 2'd2);
    bus_write(12'h078, 32'hFFFF_FFFF, 2'd2);
    bus_write(12'h0BC, 32'hFFFF_FFFF, 2'd2);
    check("R11 int ns stable", 64'(int_ns_o), before_ns);
    check("R11 int sp stable", 64'(int_sp_o), before_sp);
    check("R11 resp stable", 64'(sec_resp_o), 1);
    bus_read(12'h100, 2'd2, d); check("R11 read 0x100", 64'(d), 0);
    bus_read(12'h078, 2'd2, d); check("R11 read 0x78", 64'(d), 0);
    bus_read(12'h018, 2'd2, d); check("R11 read 0x18", 64'(d), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset("R1 initial");
    t_cfg();
    t_narrow_write();
    t_lanes();
    t_masks();
    t_readonly();
    t_clear();
    t_id();
    t_unmapped();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    t_reset("R1 second");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule